// File: doc/BRIEF.md
# Two-Clock Set/Clear Status Flag

This block is a single status bit shared by two unrelated clock domains. Logic in the producer domain raises the bit with a one-cycle request, and logic in the consumer domain lowers it the same way. Typical use is a mailbox between a data engine and a processor port. While the bit is high it tells the reader that data is waiting. While it is low it tells the writer that the mailbox may be filled again. The shared storage and the bus decode around the mailbox are not part of this block.

Two signals in different clock domains cannot both write one register. Each domain therefore owns one flip-flop, and the flag is the exclusive-OR of the two. A raising request loads the set-side flop with the inverse of the synchronised clear-side flop. A lowering request loads the clear-side flop with the synchronised set-side flop. The raw flag comes out combinationally for use outside either domain. Each domain also gets a registered copy of the flag that is safe to use in that domain. The two clocks may have any frequency and phase relationship. Each side has its own synchronous active-high reset, and both must be reset for the flag to start low.

Top module: `xflag_mailbox`

## Requirements
- R1: With both resets held for at least one edge of their own clock, `flag`, `set_side_flag` and `clr_side_flag` are all 0 once both resets are released.
- R2: A `set_req` high at a `set_clk` rising edge, with the flag settled low, makes `flag` 1 right after that edge. `set_side_flag` is still 0 after that edge and becomes 1 after the next `set_clk` edge.
- R3: A `clr_req` high at a `clr_clk` rising edge, with the flag settled high, makes `flag` 0 right after that edge. `clr_side_flag` is still 1 after that edge and becomes 0 after the next `clr_clk` edge.
- R4: A `set_req` while the flag is settled high leaves `flag` and both domain copies at 1.
- R5: A `clr_req` while the flag is settled low leaves `flag` and both domain copies at 0.
- R6: After a lowering edge on `clr_clk`, `set_side_flag` keeps its old value through the first two `set_clk` rising edges that follow. It takes the new value after the third one (SYNC_STAGES = 2).
- R7: After a raising edge on `set_clk`, `clr_side_flag` keeps its old value through the first two `clr_clk` rising edges that follow. It takes the new value after the third one (SYNC_STAGES = 2).
- R8: A `set_req` on either of the first two `set_clk` edges after a lowering edge is absorbed, and the flag stays 0. The same request on the third edge raises the flag to 1.
- R9: While neither request is asserted, `flag` and both domain copies keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| set_clk | input | 1 | Clock of the raising (producer) domain |
| set_rst | input | 1 | Synchronous active-high reset, raising domain |
| set_req | input | 1 | One-cycle request to raise the flag |
| clr_clk | input | 1 | Clock of the lowering (consumer) domain |
| clr_rst | input | 1 | Synchronous active-high reset, lowering domain |
| clr_req | input | 1 | One-cycle request to lower the flag |
| flag | output | 1 | Raw flag, exclusive-OR of the two domain flops |
| set_side_flag | output | 1 | Flag as seen in the raising domain, registered on set_clk |
| clr_side_flag | output | 1 | Flag as seen in the lowering domain, registered on clr_clk |

## Verification
The hardest situation to reach is a raising request that arrives while a lowering edge is still inside the set-side synchroniser. There the set-side flop acts on a stale copy of the clear-side flop, and the request is absorbed.

The stimulus reaches this window directly. The two clock periods are chosen so that rising edges never coincide. The bench drives `set_req` half a nanosecond after a clear edge, so the request is caught on the first, second or third following `set_clk` edge.

Randomised sequences of raise, lower and idle operations then run with random gaps, and the bench compares every settled state against a model of the flag level.

// File: rtl/xflag_pkg.sv
`timescale 1ns/1ps
package xflag_pkg;

  // Minimum synchroniser depth accepted by the design.
  localparam int unsigned XFLAG_MIN_STAGES = 2;

  // Which side of the flag a domain half implements.
  typedef enum logic {
    SIDE_CLEAR = 1'b0,
    SIDE_SET   = 1'b1
  } xflag_side_e;

endpackage

// File: rtl/xflag_sync.sv
`timescale 1ns/1ps
module xflag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned DEPTH =
    (STAGES < xflag_pkg::XFLAG_MIN_STAGES) ? xflag_pkg::XFLAG_MIN_STAGES : STAGES;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], d};
  end

  assign q = chain_q[DEPTH-1];

endmodule

// File: rtl/xflag_side.sv
`timescale 1ns/1ps
module xflag_side
  import xflag_pkg::*;
#(
  parameter xflag_side_e SIDE   = SIDE_SET,
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic remote_q,   // other domain's flop, asynchronous here
  output logic own_q,
  output logic view_q
);
  // The set side drives the XOR to 1, the clear side drives it to 0.
  localparam logic TARGET = (SIDE == SIDE_SET);

  logic remote_s;

  xflag_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (remote_q),
    .q   (remote_s)
  );

  always_ff @(posedge clk) begin
    if (rst)      own_q <= 1'b0;
    else if (req) own_q <= remote_s ^ TARGET;
  end

  always_ff @(posedge clk) begin
    if (rst) view_q <= 1'b0;
    else     view_q <= own_q ^ remote_s;
  end

  // R1: reset clears this half.
  p_rst_clears_r1: assert property (@(posedge clk)
    rst |=> (own_q == 1'b0 && view_q == 1'b0));

  // R2 on the set side, R3 on the clear side: a request lands in the view
  // one edge later when the remote copy has not moved.
  p_req_reaches_view_r2: assert property (@(posedge clk) disable iff (rst)
    (req ##1 $stable(remote_s)) |=> (view_q == TARGET));

  // R4 on the set side, R5 on the clear side: a request toward the level
  // already held leaves the own flop untouched.
  p_redundant_req_r4: assert property (@(posedge clk) disable iff (rst)
    (req && ((own_q ^ remote_s) == TARGET)) |=> $stable(own_q));

endmodule

// File: rtl/xflag_mailbox.sv
`timescale 1ns/1ps
module xflag_mailbox
  import xflag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic set_clk,
  input  logic set_rst,
  input  logic set_req,
  input  logic clr_clk,
  input  logic clr_rst,
  input  logic clr_req,
  output logic flag,
  output logic set_side_flag,
  output logic clr_side_flag
);
  logic set_q;
  logic clr_q;

  xflag_side #(.SIDE(SIDE_SET), .STAGES(SYNC_STAGES)) u_set_side (
    .clk      (set_clk),
    .rst      (set_rst),
    .req      (set_req),
    .remote_q (clr_q),
    .own_q    (set_q),
    .view_q   (set_side_flag)
  );

  xflag_side #(.SIDE(SIDE_CLEAR), .STAGES(SYNC_STAGES)) u_clr_side (
    .clk      (clr_clk),
    .rst      (clr_rst),
    .req      (clr_req),
    .remote_q (set_q),
    .own_q    (clr_q),
    .view_q   (clr_side_flag)
  );

  assign flag = set_q ^ clr_q;

  // R9: with no request, the set-domain copy only moves if the raw flag moved.
  p_idle_hold_r9: assert property (@(posedge set_clk) disable iff (set_rst)
    (!set_req && $stable(flag)) |=> $stable(set_q));

endmodule

// File: tb/xflag_mailbox_bench.sv
`timescale 1ns/1ps
module xflag_mailbox_bench;
  logic set_clk = 1'b0;
  logic clr_clk = 1'b0;
  logic set_rst = 1'b1;
  logic clr_rst = 1'b1;
  logic set_req = 1'b0;
  logic clr_req = 1'b0;
  logic flag, set_side_flag, clr_side_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic model = 1'b0;

  always #10 set_clk = ~set_clk;   // 50 MHz
  always #17 clr_clk = ~clr_clk;   // unrelated, edges never coincide

  xflag_mailbox u_xflag_mailbox (
    .set_clk(set_clk), .set_rst(set_rst), .set_req(set_req),
    .clr_clk(clr_clk), .clr_rst(clr_rst), .clr_req(clr_req),
    .flag(flag), .set_side_flag(set_side_flag), .clr_side_flag(clr_side_flag)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic next_level(input logic cur, input int op);
    if (op == 0) return 1'b1;
    if (op == 1) return 1'b0;
    return cur;
  endfunction

  task automatic pulse_set();
    @(negedge set_clk) set_req = 1'b1;
    @(posedge set_clk); #0.5 set_req = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clr_clk) clr_req = 1'b1;
    @(posedge clr_clk); #0.5 clr_req = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge set_clk);
    repeat (4) @(posedge clr_clk);
  endtask

  task automatic check_settled(input string req);
    @(negedge set_clk);
    check(req, "flag", flag, model);
    check(req, "set_side_flag", set_side_flag, model);
    @(negedge clr_clk);
    check(req, "clr_side_flag", clr_side_flag, model);
  endtask

  task automatic raise_and_settle();
    pulse_set(); model = 1'b1; settle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(posedge set_clk);
    repeat (3) @(posedge clr_clk);
    @(negedge set_clk) set_rst = 1'b0;
    @(negedge clr_clk) clr_rst = 1'b0;
    check("R1", "flag at release", flag, 1'b0);
    settle();
    check_settled("R1");

    // R2: raise and own-domain view latency
    pulse_set();
    @(negedge set_clk);
    check("R2", "flag", flag, 1'b1);
    check("R2", "set_side_flag first edge", set_side_flag, 1'b0);
    @(negedge set_clk);
    check("R2", "set_side_flag second edge", set_side_flag, 1'b1);
    model = 1'b1; settle(); check_settled("R2");

    // R4: redundant raise
    pulse_set();
    @(negedge set_clk);
    check("R4", "flag", flag, 1'b1);
    settle(); check_settled("R4");

    // R3: lower and own-domain view latency
    pulse_clr();
    @(negedge clr_clk);
    check("R3", "flag", flag, 1'b0);
    check("R3", "clr_side_flag first edge", clr_side_flag, 1'b1);
    @(negedge clr_clk);
    check("R3", "clr_side_flag second edge", clr_side_flag, 1'b0);
    model = 1'b0; settle(); check_settled("R3");

    // R5: redundant lower
    pulse_clr();
    @(negedge clr_clk);
    check("R5", "flag", flag, 1'b0);
    settle(); check_settled("R5");

    // R7: clear-domain view of a raise
    pulse_set();
    repeat (2) @(posedge clr_clk);
    @(negedge clr_clk);
    check("R7", "clr_side_flag after two edges", clr_side_flag, 1'b0);
    @(posedge clr_clk); @(negedge clr_clk);
    check("R7", "clr_side_flag after three edges", clr_side_flag, 1'b1);
    model = 1'b1; settle();

    // R6: set-domain view of a lower
    pulse_clr();
    repeat (2) @(posedge set_clk);
    @(negedge set_clk);
    check("R6", "set_side_flag after two edges", set_side_flag, 1'b1);
    @(posedge set_clk); @(negedge set_clk);
    check("R6", "set_side_flag after three edges", set_side_flag, 1'b0);
    model = 1'b0; settle();

    // R8: raise on first set edge after a lower is absorbed
    raise_and_settle();
    @(negedge clr_clk) clr_req = 1'b1;
    @(posedge clr_clk); #0.5 clr_req = 1'b0; set_req = 1'b1;
    @(posedge set_clk); #0.5 set_req = 1'b0;
    model = 1'b0; settle(); check_settled("R8");

    // R8: raise on second set edge after a lower is absorbed
    raise_and_settle();
    @(negedge clr_clk) clr_req = 1'b1;
    @(posedge clr_clk); #0.5 clr_req = 1'b0;
    @(posedge set_clk); #0.5 set_req = 1'b1;
    @(posedge set_clk); #0.5 set_req = 1'b0;
    model = 1'b0; settle(); check_settled("R8");

    // R8: raise on third set edge after a lower takes effect
    raise_and_settle();
    @(negedge clr_clk) clr_req = 1'b1;
    @(posedge clr_clk); #0.5 clr_req = 1'b0;
    repeat (2) @(posedge set_clk);
    #0.5 set_req = 1'b1;
    @(posedge set_clk); #0.5 set_req = 1'b0;
    model = 1'b1; settle(); check_settled("R8");

    // Random mix of raise, lower and idle (R2, R3, R4, R5, R9)
    for (int i = 0; i < 60; i++) begin
      int op;
      int gap;
      op  = int'($urandom % 3);
      gap = int'($urandom % 6);
      if (op == 2) begin
        repeat (gap + 3) @(posedge set_clk);
        @(negedge set_clk);
        check("R9", "flag while idle", flag, model);
        check("R9", "set_side_flag while idle", set_side_flag, model);
        @(negedge clr_clk);
        check("R9", "clr_side_flag while idle", clr_side_flag, model);
      end else begin
        if (op == 0) pulse_set(); else pulse_clr();
        model = next_level(model, op);
        repeat (gap) @(posedge set_clk);
        settle();
        check_settled(op == 0 ? "R2" : "R3");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule